// File: doc/BRIEF.md
# Serial ADC Sample Capture with Alternating Buffers

This block reads 24-bit conversion results from an external converter over a four-wire serial link. It acts as the link's master and drives clock, chip select and the outgoing data line. A rising edge on the converter's data-ready line starts one capture. The block then clocks three byte transfers in a row and keeps chip select low across all three. It joins the received bytes into one sample and writes that sample to an external sample memory.

The sample memory is split into two halves of `DEPTH` words each. Samples go into one half until it holds `DEPTH` words. Writing then moves to the other half, and a single-cycle pulse names the half that has just filled, so a consumer can drain it while the other half fills. A data-ready edge that arrives while a capture is still running is dropped, and a sticky flag records the loss.

The byte engine has a one-byte holding register in front of its shift register. Each time the holding register moves into the shift register, the sequencer refills it with the next dummy byte. This keeps the three transfers chained without software help.

Top module: `spi_sample_capture`

## Requirements
- R1: After reset, chip select is high, serial clock is low, busy is low, the overrun flag is low, the active bank is 0, and no write or full pulse is present.
- R2: Data-ready passes through a synchronizer, and only its low-to-high transition starts a capture. Holding data-ready high for any length of time starts exactly one capture.
- R3: Chip select goes low before the first serial clock edge and stays low for the whole three-byte sequence. It returns high in the cycle the sample is written. The serial clock idles low and shows no rising edge while chip select is high.
- R4: The link runs clock-idle-low with sampling on the rising edge. Each byte is received most significant bit first, and the first received byte becomes bits 23:16 of the sample, the last becomes bits 7:0.
- R5: Each capture produces exactly one write pulse. Its address is {bank, index}: bit AW-1 is the bank and the low bits are the index, which starts at 0 and rises by one per sample.
- R6: The write that fills index DEPTH-1 comes with a one-cycle full pulse whose bank output names the half just filled. From the next cycle the active bank is the other half and the index is 0.
- R7: A data-ready transition that arrives while a capture is busy sets a sticky overrun flag that only reset clears. The dropped transition starts no extra capture and produces no extra write.
- R8: A capture clocks exactly 24 serial clock rising edges as three chained bytes. The next dummy byte (parameter `DUMMY`, default 0x00, so the outgoing data line stays low) is loaded into the holding register only after the previous byte has left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_i | input | 1 | Converter data-ready, asynchronous |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Outgoing serial data (dummy bytes) |
| spi_miso_i | input | 1 | Incoming serial data from converter |
| spi_cs_n_o | output | 1 | Chip select, active low |
| buf_wr_en_o | output | 1 | Sample memory write strobe |
| buf_wr_addr_o | output | AW | Write address {bank, index} |
| buf_wr_data_o | output | 24 | Assembled sample |
| buf_full_o | output | 1 | One-cycle pulse: a half has filled |
| buf_full_idx_o | output | 1 | Half that just filled |
| wr_bank_o | output | 1 | Half currently being written |
| busy_o | output | 1 | Capture in progress |
| overrun_o | output | 1 | Sticky: a data-ready edge was lost |

## Verification
The main path is driven with a table of samples chosen so that a wrong byte order, a wrong bit order or a stuck bit gives a different word. The table holds all zeros, all ones, alternating bit patterns, a value with only its end bits set, and distinct bytes in each position. The same table runs through two full fills of both halves, which shows whether the address, the bank swap and the full pulse follow the sample count. One entry keeps data-ready high well past the end of its capture, which tells edge detection apart from level sensing. A second transition sent in the middle of a capture tells a dropped, flagged event apart from a queued one.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int SAMPLE_W   = 24;
    localparam int BYTE_W     = 8;
    localparam int BYTES_PER  = SAMPLE_W / BYTE_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/drdy_edge.sv
module drdy_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
        logic              rise;
    } edge_s;

    edge_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], async_i};
        st_d.prev = st_q.sync[STAGES-1];
        st_d.rise = st_q.sync[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.rise;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rise |=> !st_q.rise); // R2
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_wr_i,
    input  logic [7:0] hold_data_i,
    output logic       taken_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_byte_o,
    output logic       sclk_o,
    output logic       mosi_o,
    input  logic       miso_i
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    typedef struct packed {
        logic             hold_full;
        logic [7:0]       hold;
        logic [7:0]       shift;
        logic [7:0]       rx_sh;
        logic [2:0]       bit_cnt;
        logic [DIV_W-1:0] div_cnt;
        logic             sclk;
        logic             active;
        logic             taken;
        logic             rx_valid;
        logic [7:0]       rx_byte;
    } eng_s;

    eng_s st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.taken    = 1'b0;
        st_d.rx_valid = 1'b0;
        if (!st_q.active) begin
            if (st_q.hold_full) begin
                st_d.shift     = st_q.hold;
                st_d.hold_full = 1'b0;
                st_d.active    = 1'b1;
                st_d.bit_cnt   = '0;
                st_d.div_cnt   = '0;
                st_d.taken     = 1'b1;
            end
        end else if (st_q.div_cnt == DIV_LAST) begin
            st_d.div_cnt = '0;
            st_d.sclk    = ~st_q.sclk;
            if (!st_q.sclk) begin
                st_d.rx_sh = {st_q.rx_sh[6:0], miso_i};
            end else begin
                st_d.shift   = {st_q.shift[6:0], 1'b0};
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    st_d.active   = 1'b0;
                    st_d.rx_valid = 1'b1;
                    st_d.rx_byte  = st_q.rx_sh;
                end
            end
        end else begin
            st_d.div_cnt = st_q.div_cnt + DIV_W'(1);
        end
        if (hold_wr_i) begin
            st_d.hold      = hold_data_i;
            st_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taken_o    = st_q.taken;
    assign rx_valid_o = st_q.rx_valid;
    assign rx_byte_o  = st_q.rx_byte;
    assign sclk_o     = st_q.sclk;
    assign mosi_o     = st_q.active & st_q.shift[7];

    AST_HOLD_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr_i |-> !st_q.hold_full); // R8
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !st_q.sclk); // R3
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_valid |=> !st_q.rx_valid); // R8
endmodule

// File: rtl/capture_seq.sv
module capture_seq
    import cap_pkg::*;
#(
    parameter int         DEPTH = 4,
    parameter logic [7:0] DUMMY = 8'h00,
    parameter int         AW    = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_i,
    input  logic                taken_i,
    input  logic                rx_valid_i,
    input  logic [7:0]          rx_byte_i,
    output logic                hold_wr_o,
    output logic [7:0]          hold_data_o,
    output logic                cs_n_o,
    output logic                wr_en_o,
    output logic [AW-1:0]       wr_addr_o,
    output logic [SAMPLE_W-1:0] wr_data_o,
    output logic                full_o,
    output logic                full_idx_o,
    output logic                bank_o,
    output logic                busy_o,
    output logic                overrun_o
);
    localparam int IDX_W = AW - 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
    localparam logic [1:0] LAST_BYTE = 2'(BYTES_PER - 1);

    typedef struct packed {
        cap_state_e          state;
        logic                cs_n;
        logic                hold_wr;
        logic [1:0]          loaded;
        logic [1:0]          rx_cnt;
        logic [15:0]         word;
        logic [IDX_W-1:0]    idx;
        logic                bank;
        logic                wr_en;
        logic [AW-1:0]       wr_addr;
        logic [SAMPLE_W-1:0] wr_data;
        logic                full;
        logic                full_idx;
        logic                overrun;
    } seq_s;

    seq_s st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.hold_wr = 1'b0;
        st_d.wr_en   = 1'b0;
        st_d.full    = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (trig_i) begin
                    st_d.state   = ST_RUN;
                    st_d.cs_n    = 1'b0;
                    st_d.hold_wr = 1'b1;
                    st_d.loaded  = 2'd1;
                    st_d.rx_cnt  = '0;
                end
            end
            ST_RUN: begin
                if (trig_i) st_d.overrun = 1'b1;
                if (taken_i && st_q.loaded != 2'(BYTES_PER)) begin
                    st_d.hold_wr = 1'b1;
                    st_d.loaded  = st_q.loaded + 2'd1;
                end
                if (rx_valid_i) begin
                    st_d.word = {st_q.word[7:0], rx_byte_i};
                    if (st_q.rx_cnt == LAST_BYTE) begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_data = {st_q.word, rx_byte_i};
                        st_d.wr_addr = {st_q.bank, st_q.idx};
                        st_d.cs_n    = 1'b1;
                        st_d.state   = ST_IDLE;
                        if (st_q.idx == IDX_LAST) begin
                            st_d.idx      = '0;
                            st_d.bank     = ~st_q.bank;
                            st_d.full     = 1'b1;
                            st_d.full_idx = st_q.bank;
                        end else begin
                            st_d.idx = st_q.idx + IDX_W'(1);
                        end
                    end else begin
                        st_d.rx_cnt = st_q.rx_cnt + 2'd1;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_wr_o   = st_q.hold_wr;
    assign hold_data_o = DUMMY;
    assign cs_n_o      = st_q.cs_n;
    assign wr_en_o     = st_q.wr_en;
    assign wr_addr_o   = st_q.wr_addr;
    assign wr_data_o   = st_q.wr_data;
    assign full_o      = st_q.full;
    assign full_idx_o  = st_q.full_idx;
    assign bank_o      = st_q.bank;
    assign busy_o      = (st_q.state == ST_RUN);
    assign overrun_o   = st_q.overrun;

    AST_FULL_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> st_q.wr_en); // R6
    AST_FULL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |=> !st_q.full); // R6
    AST_BANK_SWAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> (st_q.bank != st_q.full_idx)); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.overrun |=> st_q.overrun); // R7
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> st_q.cs_n); // R3
    AST_CS_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_RUN) |-> !st_q.cs_n); // R3
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |=> !st_q.wr_en); // R5
endmodule

// File: rtl/spi_sample_capture.sv
module spi_sample_capture
    import cap_pkg::*;
#(
    parameter int         DEPTH       = 4,
    parameter int         CLK_DIV     = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DUMMY       = 8'h00,
    parameter int         AW          = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                drdy_i,
    output logic                spi_sclk_o,
    output logic                spi_mosi_o,
    input  logic                spi_miso_i,
    output logic                spi_cs_n_o,
    output logic                buf_wr_en_o,
    output logic [AW-1:0]       buf_wr_addr_o,
    output logic [SAMPLE_W-1:0] buf_wr_data_o,
    output logic                buf_full_o,
    output logic                buf_full_idx_o,
    output logic                wr_bank_o,
    output logic                busy_o,
    output logic                overrun_o
);
    logic       trig;
    logic       hold_wr;
    logic [7:0] hold_data;
    logic       taken;
    logic       rx_valid;
    logic [7:0] rx_byte;

    drdy_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (drdy_i),
        .rise_o  (trig)
    );

    spi_byte_engine #(.CLK_DIV(CLK_DIV)) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_wr_i   (hold_wr),
        .hold_data_i (hold_data),
        .taken_o     (taken),
        .rx_valid_o  (rx_valid),
        .rx_byte_o   (rx_byte),
        .sclk_o      (spi_sclk_o),
        .mosi_o      (spi_mosi_o),
        .miso_i      (spi_miso_i)
    );

    capture_seq #(.DEPTH(DEPTH), .DUMMY(DUMMY), .AW(AW)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .taken_i     (taken),
        .rx_valid_i  (rx_valid),
        .rx_byte_i   (rx_byte),
        .hold_wr_o   (hold_wr),
        .hold_data_o (hold_data),
        .cs_n_o      (spi_cs_n_o),
        .wr_en_o     (buf_wr_en_o),
        .wr_addr_o   (buf_wr_addr_o),
        .wr_data_o   (buf_wr_data_o),
        .full_o      (buf_full_o),
        .full_idx_o  (buf_full_idx_o),
        .bank_o      (wr_bank_o),
        .busy_o      (busy_o),
        .overrun_o   (overrun_o)
    );

    AST_NO_SCLK_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sclk_o); // R3
endmodule

// File: tb/test_spi_sample_capture.sv
module test_spi_sample_capture;
    localparam int DEPTH = 4;
    localparam int AW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drdy = 1'b0;
    logic miso;
    logic sclk, mosi, cs_n, wr_en, full, full_idx, bank, busy, ovr;
    logic [AW-1:0] wr_addr;
    logic [23:0]   wr_data;

    always #10 clk = ~clk;

    spi_sample_capture #(.DEPTH(DEPTH), .CLK_DIV(2)) i_spi_sample_capture (
        .clk(clk), .rst_n(rst_n), .drdy_i(drdy),
        .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_cs_n_o(cs_n),
        .buf_wr_en_o(wr_en), .buf_wr_addr_o(wr_addr), .buf_wr_data_o(wr_data),
        .buf_full_o(full), .buf_full_idx_o(full_idx), .wr_bank_o(bank),
        .busy_o(busy), .overrun_o(ovr)
    );

    // converter model: clock-idle-low, data changes on falling edge
    logic [23:0] adc_word = '0;
    logic [23:0] adc_sh = '0;
    assign miso = adc_sh[23];
    always @(negedge cs_n) adc_sh <= adc_word;
    always @(negedge sclk) if (!cs_n) adc_sh <= {adc_sh[22:0], 1'b0};

    // port monitor sampled mid-cycle
    int wr_count = 0, full_count = 0, edges = 0, stray = 0, mosi_hi = 0;
    logic [23:0] last_data = '0;
    logic [AW-1:0] last_addr = '0;
    logic last_full_idx = 1'b0;
    logic prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (wr_en) begin wr_count++; last_data = wr_data; last_addr = wr_addr; end
        if (full) begin full_count++; last_full_idx = full_idx; end
        if (sclk && !prev_sclk) begin
            if (cs_n) stray++; else edges++;
        end
        if (!cs_n && mosi) mosi_hi++;
        prev_sclk = sclk;
    end

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {hold data-ready long, sample, expected address}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 24'h000000, 3'd0},
        {1'b0, 24'hFFFFFF, 3'd1},
        {1'b0, 24'hA5A5A5, 3'd2},
        {1'b1, 24'h800001, 3'd3},
        {1'b0, 24'h123456, 3'd4},
        {1'b0, 24'h7FFFFE, 3'd5},
        {1'b0, 24'h0F0F0F, 3'd6},
        {1'b0, 24'hC3C33C, 3'd7}
    };

    bit done = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        check(busy == 1'b0 && ovr == 1'b0, "R1 busy/overrun", {busy, ovr}, 0);
        check(bank == 1'b0 && !wr_en && !full, "R1 bank/strobes", {bank, wr_en, full}, 0);

        for (int k = 0; k < 8; k++) begin
            adc_word = VEC[k][26:3];
            edges = 0;
            @(negedge clk) drdy = 1'b1;
            repeat (VEC[k][27] ? 400 : 6) @(negedge clk);
            drdy = 1'b0;
            repeat (300) @(negedge clk);
            check(wr_count == k + 1, "R2 one capture per edge", wr_count, k + 1);
            check(last_data == VEC[k][26:3], "R4 assembled sample", last_data, VEC[k][26:3]);
            check(last_addr == VEC[k][2:0], "R5 write address", last_addr, VEC[k][2:0]);
            check(edges == 24, "R8 clock edges per sample", edges, 24);
            if (k == 3) begin
                check(full_count == 1 && last_full_idx == 1'b0, "R6 first half full", {full_count, last_full_idx}, 2);
                check(bank == 1'b1, "R6 bank after swap", bank, 1);
            end
            if (k == 7) begin
                check(full_count == 2 && last_full_idx == 1'b1, "R6 second half full", {full_count, last_full_idx}, 5);
                check(bank == 1'b0, "R6 bank back to 0", bank, 0);
            end
        end
        check(stray == 0, "R3 no clock while deselected", stray, 0);
        check(mosi_hi == 0, "R8 dummy byte on mosi", mosi_hi, 0);
        check(ovr == 1'b0, "R7 no overrun yet", ovr, 0);

        // R7 second edge during a capture
        adc_word = 24'h5A3C96;
        @(negedge clk) drdy = 1'b1;
        repeat (5) @(negedge clk) drdy = 1'b1;
        drdy = 1'b0;
        repeat (30) @(negedge clk);
        check(busy == 1'b1, "R7 capture busy", busy, 1);
        drdy = 1'b1;
        repeat (5) @(negedge clk);
        drdy = 1'b0;
        repeat (400) @(negedge clk);
        check(ovr == 1'b1, "R7 overrun flag", ovr, 1);
        check(wr_count == 9, "R7 dropped edge not queued", wr_count, 9);
        check(last_data == 24'h5A3C96 && last_addr == 3'd0, "R5 R4 sample after wrap", last_data, 24'h5A3C96);

        // R1 reset clears sticky flag and bank position
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ovr == 1'b0 && cs_n == 1'b1, "R1 after reset", {ovr, cs_n}, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule